// File: doc/BRIEF.md
# ADC Result Register Bank

This block keeps the most recent conversion result for each of a set of analog channels. Each channel has one data register and a flag that marks a result nobody has read yet. The conversion sequencer writes results through a strobe, a channel index and a raw sample whose width is set by a parameter. The CPU side reads one channel at a time. It receives a 16-bit presented value and the channel's unread flag, and the read also consumes the flag.

Two global settings control the bank. The first is an overwrite policy. When it is off, a result that arrives for a channel still holding an unread result is dropped, and a one-cycle indication goes out. When it is on, new results always replace the stored one. The second is an alignment setting that chooses right or left justification inside the 16-bit field. Raw samples are stored unchanged and justified only on the read path, so a change of alignment applies to every channel at the same moment.

Top module: `adc_result_bank`

## Requirements
- R1: After reset every channel reads back as data 0 with the unread flag 0, `drop_pulse` is 0, alignment is right-justified and overwrite is disabled.
- R2: A write strobe to a channel with no unread result stores the sample and sets that channel's unread flag.
- R3: With overwrite disabled, a write to a channel whose flag is set is dropped and the old sample is kept. `drop_pulse` is 1 in the cycle after that write and only then.
- R4: With overwrite enabled, a write always replaces the stored sample and `drop_pulse` stays 0.
- R5: `rd_data` and `rd_valid` show the addressed channel one cycle after `rd_en`. The read clears the flag, so an immediate second read returns the same data with `rd_valid` 0.
- R6: When a read and a write hit the same channel in the same cycle, the read returns the old sample and flag. The write is accepted even with overwrite disabled, and the flag remains 1.
- R7: With alignment 0, the sample occupies `rd_data[RES_BITS-1:0]` and the upper bits read 0.
- R8: With alignment 1, the sample occupies `rd_data[15:16-RES_BITS]` and the lower bits read 0.
- R9: `cfg_we` loads `cfg_ovr_en` and `cfg_left` for use from the next cycle on. An alignment change affects reads of every channel, including samples stored before the change.
- R10: While `rd_en` is 0, `rd_data` and `rd_valid` hold their last values.
- R11: A write to one channel changes neither the data nor the flag of any other channel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_we | input | 1 | Load the global settings |
| cfg_ovr_en | input | 1 | Overwrite policy value to load |
| cfg_left | input | 1 | Alignment value to load (1 = left) |
| wr_en | input | 1 | Result write strobe from the sequencer |
| wr_ch | input | $clog2(NUM_CH) | Channel being written |
| wr_data | input | RES_BITS | Raw conversion sample |
| rd_en | input | 1 | CPU read strobe |
| rd_ch | input | $clog2(NUM_CH) | Channel being read |
| rd_data | output | 16 | Justified sample of the last read |
| rd_valid | output | 1 | Unread flag of the last read, sampled before it was cleared |
| drop_pulse | output | 1 | One-cycle pulse for a dropped result |

## Verification
Every result of this block arrives exactly one clock edge after the input that causes it. This applies to read data, the read flag, the drop pulse and the effect of a settings load. The bench drives each input on the falling edge and then passes one rising edge. It samples on the following falling edge, so every comparison falls inside the cycle where the result is due. The expected value comes from a model in the bench. The model is updated in the same step, using the channel contents and settings as they stood before that edge.

// File: rtl/adc_bank_pkg.sv
package adc_bank_pkg;
  localparam int unsigned FIELD_W = 16;

  // Justify a zero-extended raw sample in the 16-bit field.
  function automatic logic [FIELD_W-1:0] justify(input logic [FIELD_W-1:0] raw_ext,
                                                 input int unsigned res,
                                                 input logic left);
    logic [FIELD_W-1:0] r;
    if (left) r = raw_ext << (FIELD_W - res);
    else      r = raw_ext;
    return r;
  endfunction

  // Bits above the sample in right-justified form.
  function automatic logic [FIELD_W-1:0] high_mask(input int unsigned res);
    return ~((FIELD_W'(1) << res) - FIELD_W'(1));
  endfunction

  // Bits below the sample in left-justified form.
  function automatic logic [FIELD_W-1:0] low_mask(input int unsigned res);
    return (FIELD_W'(1) << (FIELD_W - res)) - FIELD_W'(1);
  endfunction
endpackage

// File: rtl/bank_cfg_reg.sv
module bank_cfg_reg (
  input  logic clk,
  input  logic rst_n,
  input  logic cfg_we,
  input  logic cfg_ovr_en,
  input  logic cfg_left,
  output logic ovr_q,
  output logic left_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ovr_q  <= 1'b0;
      left_q <= 1'b0;
    end else if (cfg_we) begin
      ovr_q  <= cfg_ovr_en;
      left_q <= cfg_left;
    end
  end
endmodule

// File: rtl/bank_channel.sv
module bank_channel #(
  parameter int unsigned RES_BITS = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_hit,
  input  logic                rd_hit,
  input  logic                ovr_en,
  input  logic [RES_BITS-1:0] wr_data,
  output logic [RES_BITS-1:0] data_q,
  output logic                valid_q,
  output logic                accept_evt,
  output logic                drop_evt
);
  // A same-cycle read consumes the old sample, so the slot is free.
  assign accept_evt = wr_hit && (ovr_en || !valid_q || rd_hit);
  assign drop_evt   = wr_hit && !accept_evt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      if (accept_evt) data_q <= wr_data;
      if (accept_evt)  valid_q <= 1'b1;
      else if (rd_hit) valid_q <= 1'b0;
    end
  end
endmodule

// File: rtl/bank_read_port.sv
module bank_read_port
  import adc_bank_pkg::*;
#(
  parameter int unsigned NUM_CH   = 8,
  parameter int unsigned RES_BITS = 10,
  localparam int unsigned CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rd_en,
  input  logic [CH_W-1:0]     rd_ch,
  input  logic                left_q,
  input  logic [RES_BITS-1:0] data_arr [NUM_CH],
  input  logic [NUM_CH-1:0]   valid_vec,
  output logic [FIELD_W-1:0]  rd_data,
  output logic                rd_valid
);
  logic [FIELD_W-1:0] sel_ext;
  logic [FIELD_W-1:0] presented;

  assign sel_ext   = FIELD_W'(data_arr[rd_ch]);
  assign presented = justify(sel_ext, RES_BITS, left_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else if (rd_en) begin
      rd_data  <= presented;
      rd_valid <= valid_vec[rd_ch];
    end
  end
endmodule

// File: rtl/adc_result_bank.sv
module adc_result_bank #(
  parameter int unsigned NUM_CH   = 8,
  parameter int unsigned RES_BITS = 10,
  localparam int unsigned CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_we,
  input  logic                cfg_ovr_en,
  input  logic                cfg_left,
  input  logic                wr_en,
  input  logic [CH_W-1:0]     wr_ch,
  input  logic [RES_BITS-1:0] wr_data,
  input  logic                rd_en,
  input  logic [CH_W-1:0]     rd_ch,
  output logic [15:0]         rd_data,
  output logic                rd_valid,
  output logic                drop_pulse
);
  logic                ovr_q;
  logic                left_q;
  logic [RES_BITS-1:0] data_arr [NUM_CH];
  logic [NUM_CH-1:0]   valid_vec;
  logic [NUM_CH-1:0]   accept_vec;
  logic [NUM_CH-1:0]   drop_vec;

  bank_cfg_reg u_cfg (
    .clk       (clk),
    .rst_n     (rst_n),
    .cfg_we    (cfg_we),
    .cfg_ovr_en(cfg_ovr_en),
    .cfg_left  (cfg_left),
    .ovr_q     (ovr_q),
    .left_q    (left_q)
  );

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic wr_hit;
    logic rd_hit;
    assign wr_hit = wr_en && (wr_ch == CH_W'(c));
    assign rd_hit = rd_en && (rd_ch == CH_W'(c));
    bank_channel #(.RES_BITS(RES_BITS)) u_ch (
      .clk       (clk),
      .rst_n     (rst_n),
      .wr_hit    (wr_hit),
      .rd_hit    (rd_hit),
      .ovr_en    (ovr_q),
      .wr_data   (wr_data),
      .data_q    (data_arr[c]),
      .valid_q   (valid_vec[c]),
      .accept_evt(accept_vec[c]),
      .drop_evt  (drop_vec[c])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) drop_pulse <= 1'b0;
    else        drop_pulse <= |drop_vec;
  end

  bank_read_port #(.NUM_CH(NUM_CH), .RES_BITS(RES_BITS)) u_rd (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_en    (rd_en),
    .rd_ch    (rd_ch),
    .left_q   (left_q),
    .data_arr (data_arr),
    .valid_vec(valid_vec),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );
endmodule

// File: rtl/adc_bank_chk.sv
module adc_bank_chk
  import adc_bank_pkg::*;
#(
  parameter int unsigned NUM_CH   = 8,
  parameter int unsigned RES_BITS = 10,
  localparam int unsigned CH_W    = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              wr_en,
  input logic [CH_W-1:0]   wr_ch,
  input logic              rd_en,
  input logic [15:0]       rd_data,
  input logic              rd_valid,
  input logic              drop_pulse,
  input logic              ovr_q,
  input logic              left_q,
  input logic [NUM_CH-1:0] valid_vec,
  input logic [NUM_CH-1:0] accept_vec,
  input logic [NUM_CH-1:0] drop_vec
);
  localparam logic [15:0] HI_M = high_mask(RES_BITS);
  localparam logic [15:0] LO_M = low_mask(RES_BITS);

  // R3
  drop_needs_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_pulse |-> ($past(wr_en) && !$past(ovr_q)));
  // R4
  no_drop_with_ovr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $past(ovr_q) |-> !drop_pulse);
  // R11
  one_channel_written_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(accept_vec | drop_vec));
  // R2
  accepted_sets_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    |accept_vec |=> valid_vec[$past(wr_ch)]);
  // R7
  right_high_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_en) && !$past(left_q)) |-> ((rd_data & HI_M) == 16'h0));
  // R8
  left_low_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rd_en) && $past(left_q)) |-> ((rd_data & LO_M) == 16'h0));
  // R10
  hold_when_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rd_en) |-> ($stable(rd_data) && $stable(rd_valid)));
endmodule

bind adc_result_bank adc_bank_chk #(.NUM_CH(NUM_CH), .RES_BITS(RES_BITS)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_ch     (wr_ch),
  .rd_en     (rd_en),
  .rd_data   (rd_data),
  .rd_valid  (rd_valid),
  .drop_pulse(drop_pulse),
  .ovr_q     (ovr_q),
  .left_q    (left_q),
  .valid_vec (valid_vec),
  .accept_vec(accept_vec),
  .drop_vec  (drop_vec)
);

// File: tb/tb_adc_result_bank.sv
module tb_adc_result_bank;
  localparam int NCH = 8;
  localparam int RES = 10;
  localparam int CW  = 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 0, cfg_ovr_en = 0, cfg_left = 0;
  logic wr_en = 0, rd_en = 0;
  logic [CW-1:0] wr_ch = '0, rd_ch = '0;
  logic [RES-1:0] wr_data = '0;
  logic [15:0] rd_data;
  logic rd_valid, drop_pulse;

  int checks = 0;
  int errors = 0;

  logic [RES-1:0] m_data [NCH];
  logic           m_valid [NCH];
  logic           m_ovr = 0, m_left = 0;
  logic [15:0]    e_rd = '0;
  logic           e_rv = 0;

  always #4 clk = ~clk;

  adc_result_bank #(.NUM_CH(NCH), .RES_BITS(RES)) dut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_ovr_en(cfg_ovr_en),
    .cfg_left(cfg_left), .wr_en(wr_en), .wr_ch(wr_ch), .wr_data(wr_data),
    .rd_en(rd_en), .rd_ch(rd_ch), .rd_data(rd_data), .rd_valid(rd_valid),
    .drop_pulse(drop_pulse)
  );

  // Bit-by-bit placement of a sample, written independently of the RTL.
  function automatic logic [15:0] place(input logic [RES-1:0] s, input logic left);
    logic [15:0] v = '0;
    for (int b = 0; b < RES; b++) begin
      if (left) v[16 - RES + b] = s[b];
      else      v[b] = s[b];
    end
    return v;
  endfunction

  task automatic check(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  // One clock: drive at the falling edge, update the model, compare one edge later.
  task automatic step(input string tag, input logic w, input int wc, input int wd,
                      input logic r, input int rc);
    logic e_drop;
    wr_en = w; wr_ch = CW'(wc); wr_data = RES'(wd);
    rd_en = r; rd_ch = CW'(rc);
    e_drop = 0;
    if (r) begin
      e_rd = place(m_data[rc], m_left);
      e_rv = m_valid[rc];
    end
    if (w) begin
      if (m_valid[wc] && !m_ovr && !(r && rc == wc)) e_drop = 1;
    end
    if (r) m_valid[rc] = 0;
    if (w && !e_drop) begin
      m_data[wc]  = RES'(wd);
      m_valid[wc] = 1;
    end
    @(posedge clk);
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    check(tag, "rd_data", int'(rd_data), int'(e_rd));
    check(tag, "rd_valid", int'(rd_valid), int'(e_rv));
    check(tag, "drop_pulse", int'(drop_pulse), int'(e_drop));
  endtask

  task automatic set_cfg(input logic ovr, input logic left);
    cfg_we = 1; cfg_ovr_en = ovr; cfg_left = left;
    @(posedge clk);
    @(negedge clk);
    cfg_we = 0;
    m_ovr = ovr; m_left = left;
  endtask

  task automatic t_reset();
    for (int c = 0; c < NCH; c++) step("R1", 0, 0, 0, 1, c);
  endtask

  task automatic t_store_and_read();
    step("R2", 1, 2, 'h2A5, 0, 0);
    step("R5", 0, 0, 0, 1, 2);
    step("R5", 0, 0, 0, 1, 2);
    step("R7", 1, 0, 'h3FF, 0, 0);
    step("R7", 0, 0, 0, 1, 0);
  endtask

  task automatic t_discard();
    step("R2", 1, 3, 'h111, 0, 0);
    step("R3", 1, 3, 'h222, 0, 0);
    step("R3", 0, 0, 0, 0, 0);
    step("R3", 0, 0, 0, 1, 3);
  endtask

  task automatic t_overwrite();
    set_cfg(1, 0);
    step("R4", 1, 4, 'h0F0, 0, 0);
    step("R4", 1, 4, 'h30F, 0, 0);
    step("R4", 0, 0, 0, 1, 4);
    set_cfg(0, 0);
  endtask

  task automatic t_align();
    step("R8", 1, 5, 'h3FF, 0, 0);
    step("R8", 1, 1, 'h001, 0, 0);
    set_cfg(0, 1);
    step("R8", 0, 0, 0, 1, 5);
    step("R8", 0, 0, 0, 1, 1);
    set_cfg(0, 0);
    step("R9", 0, 0, 0, 1, 5);
    step("R9", 0, 0, 0, 1, 1);
  endtask

  task automatic t_collide();
    step("R6", 1, 6, 'h0AA, 0, 0);
    step("R6", 1, 6, 'h155, 1, 6);
    step("R6", 0, 0, 0, 1, 6);
  endtask

  task automatic t_hold_isolate();
    step("R11", 1, 7, 'h2C3, 0, 0);
    step("R11", 0, 0, 0, 1, 7);
    step("R10", 1, 0, 'h011, 0, 0);
    step("R10", 1, 7, 'h099, 0, 0);
    step("R11", 0, 0, 0, 1, 0);
    step("R11", 0, 0, 0, 1, 2);
  endtask

  initial begin
    #(8 * 100000);
    errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    for (int c = 0; c < NCH; c++) begin
      m_data[c] = '0;
      m_valid[c] = 0;
    end
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    check("R1", "drop_pulse", int'(drop_pulse), 0);
    t_reset();
    t_store_and_read();
    t_discard();
    t_overwrite();
    t_align();
    t_collide();
    t_hold_isolate();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule